// File: doc/BRIEF.md
# Flash Read-Protection Level Controller

This block holds the protection option byte of an embedded flash and turns it into one of three read-protection levels: open, guarded or locked. From the current level, the boot source and whether a debugger is attached, it decides whether each access to user flash or backup SRAM may go ahead. A blocked read answers with a bus error.

It also handles writes to the option byte. A write is accepted, rejected with a one-cycle error pulse, or accepted only after an external mass erase of the user flash and backup SRAM has completed. An erase is needed when leaving the guarded level for the open level. The locked level can never be left. At the locked level the debug, trace and boundary-scan enable is off, and so is permission to boot from RAM or from the system bootloader. The flash array, the erase sequencing and the one-time-programmable area are outside the block. Other option bytes and write-protection settings are not touched by the erase handshake.

Top module: `rdprot_ctrl`

## Requirements
- R1: The stored byte decodes by exact match: 0xAA gives level 0, 0xCC gives level 2, and any other value gives level 1. `protLevel` shows the level as 0, 1 or 2. After reset the stored byte is the erased value 0xFF, so the level is 1.
- R2: At level 0, every request gets `accGrant` whatever the boot source and debug state are. The only exception is R10.
- R3: `bootSel` codes are 0 for flash, 1 for the system bootloader, and 2 or 3 for RAM. At level 1 or 2, a request is blocked while `dbgConnected` is high or `bootSel` is not 0. A blocked read (`accWrite`=0) raises `accBusErr`. A blocked write raises neither output. Both responses appear in the cycle after the request.
- R4: At level 1 or 2, booting from flash (`bootSel`=0) with no debugger attached, both reads and writes are granted.
- R5: An option write of 0xAA while at level 1 raises `eraseReq` in the next cycle. `eraseReq` stays high until `eraseDone` is sampled high. Only then is 0xAA committed, so the level falls to 0 only after the erase.
- R6: While `eraseReq` is high, no access is granted, and every read gets `accBusErr`.
- R7: Any other write accepted at level 0 or 1 needs no erase. This includes raising the level (0 to 1, 1 to 2, 0 to 2). A request sampled at edge E is committed at edge E+1, and the new `protLevel` appears after edge E+2.
- R8: At level 2, every option write is rejected and the level stays 2. `dbgPortEn`, `bootRamAllowed` and `bootLoaderAllowed` are low at level 2 and high at the other levels.
- R9: An option write made during an erase, or before the level from the previous write is visible, is rejected. A rejected write gives an `optWrErr` pulse in the next cycle and leaves the stored byte unchanged.
- R10: A write request with `wrLock` high is never granted and never gets `accBusErr`, at any level. `wrLock` has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootSel | input | 2 | Boot source: 0 flash, 1 system bootloader, 2/3 RAM |
| dbgConnected | input | 1 | Debugger attached |
| accReq | input | 1 | Flash or backup SRAM access request |
| accWrite | input | 1 | 1 = program or erase, 0 = read |
| wrLock | input | 1 | Write protection covers the addressed area |
| optWrReq | input | 1 | Option-byte write request |
| optWrByte | input | 8 | New option-byte value |
| eraseDone | input | 1 | Mass erase finished |
| accGrant | output | 1 | Access allowed (one cycle after the request) |
| accBusErr | output | 1 | Blocked read, bus error |
| optWrErr | output | 1 | Option write rejected (pulse) |
| eraseReq | output | 1 | Mass erase request, held until done |
| protLevel | output | 2 | Current protection level |
| dbgPortEn | output | 1 | Debug, trace and boundary-scan enable |
| bootRamAllowed | output | 1 | Booting from RAM permitted |
| bootLoaderAllowed | output | 1 | Booting from the system bootloader permitted |

## Verification
The delicate coincidences are `eraseDone` arriving in the same cycle as an access request, and `eraseDone` arriving in the same cycle as a fresh option write. The access must still be refused, because the erase is pending when it is sampled. The option write must be rejected, because the controller is still busy. Both cases are provoked on purpose in the directed sequence, and many more times by randomised stimulus. A behavioural model in the bench tracks the pending write, the erase and the level, and every output is compared against it on every clock.

// File: rtl/rdp_pkg.sv
`timescale 1ns/1ps
package rdp_pkg;
  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_GUARD = 2'd1,
    LVL_LOCK  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_COMMIT,
    ST_SETTLE
  } opt_st_e;

  localparam logic [1:0] BOOT_FLASH = 2'd0;

  // strobes from the option-write control to the datapath
  typedef struct packed {
    logic commit;
    logic eraseHold;
    logic wrReject;
  } strobe_t;
endpackage

// File: rtl/rdp_opt_ctrl.sv
`timescale 1ns/1ps
module rdp_opt_ctrl
  import rdp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              optWrReq,
  input  logic [BYTE_W-1:0] optWrByte,
  input  logic              eraseDone,
  input  lvl_e              level,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] pendByte
);
  opt_st_e state, nextState;
  logic    rejectNow, acceptNow, wrErrQ;

  always_comb begin
    nextState = state;
    rejectNow = 1'b0;
    acceptNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (optWrReq) begin
          if (level == LVL_LOCK) begin
            rejectNow = 1'b1;
          end else begin
            acceptNow = 1'b1;
            // leaving the guarded level for the open one needs a wipe first
            if (level == LVL_GUARD && optWrByte == OPEN_CODE)
              nextState = ST_ERASE;
            else
              nextState = ST_COMMIT;
          end
        end
      end
      ST_ERASE: begin
        rejectNow = optWrReq;
        if (eraseDone) nextState = ST_COMMIT;
      end
      ST_COMMIT: begin
        rejectNow = optWrReq;
        nextState = ST_SETTLE;
      end
      default: begin
        // level register catches up with the new byte here
        rejectNow = optWrReq;
        nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendByte <= '0;
      wrErrQ   <= 1'b0;
    end else begin
      state  <= nextState;
      wrErrQ <= rejectNow;
      if (acceptNow) pendByte <= optWrByte;
    end
  end

  assign stb.commit    = (state == ST_COMMIT);
  assign stb.eraseHold = (state == ST_ERASE);
  assign stb.wrReject  = wrErrQ;
endmodule

// File: rtl/rdp_datapath.sv
`timescale 1ns/1ps
module rdp_datapath
  import rdp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE  = 8'hAA,
  parameter logic [BYTE_W-1:0] LOCK_CODE  = 8'hCC,
  parameter logic [BYTE_W-1:0] BLANK_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] pendByte,
  input  logic              accReq,
  input  logic              accWrite,
  input  logic              wrLock,
  input  logic [1:0]        bootSel,
  input  logic              dbgConnected,
  output lvl_e              level,
  output logic              accGrant,
  output logic              accBusErr
);
  function automatic lvl_e decodeLevel(input logic [BYTE_W-1:0] b);
    if (b == OPEN_CODE)      return LVL_OPEN;
    else if (b == LOCK_CODE) return LVL_LOCK;
    else                     return LVL_GUARD;
  endfunction

  localparam lvl_e RESET_LVL = decodeLevel(BLANK_CODE);

  logic [BYTE_W-1:0] optByteQ;
  logic              untrusted, blocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      optByteQ <= BLANK_CODE;
      level    <= RESET_LVL;
    end else begin
      if (stb.commit) optByteQ <= pendByte;
      level <= decodeLevel(optByteQ);
    end
  end

  assign untrusted = dbgConnected || (bootSel != BOOT_FLASH);
  assign blocked   = stb.eraseHold
                   || ((level != LVL_OPEN) && untrusted)
                   || (accWrite && wrLock);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accGrant  <= 1'b0;
      accBusErr <= 1'b0;
    end else begin
      accGrant  <= accReq && !blocked;
      accBusErr <= accReq && !accWrite && blocked;
    end
  end
endmodule

// File: rtl/rdprot_ctrl.sv
`timescale 1ns/1ps
module rdprot_ctrl
  import rdp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPEN_CODE  = 8'hAA,
  parameter logic [BYTE_W-1:0] LOCK_CODE  = 8'hCC,
  parameter logic [BYTE_W-1:0] BLANK_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bootSel,
  input  logic              dbgConnected,
  input  logic              accReq,
  input  logic              accWrite,
  input  logic              wrLock,
  input  logic              optWrReq,
  input  logic [BYTE_W-1:0] optWrByte,
  input  logic              eraseDone,
  output logic              accGrant,
  output logic              accBusErr,
  output logic              optWrErr,
  output logic              eraseReq,
  output logic [1:0]        protLevel,
  output logic              dbgPortEn,
  output logic              bootRamAllowed,
  output logic              bootLoaderAllowed
);
  strobe_t           stb;
  logic [BYTE_W-1:0] pendByte;
  lvl_e              level;

  rdp_opt_ctrl #(.BYTE_W(BYTE_W), .OPEN_CODE(OPEN_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .optWrReq(optWrReq), .optWrByte(optWrByte),
    .eraseDone(eraseDone), .level(level), .stb(stb), .pendByte(pendByte)
  );

  rdp_datapath #(
    .BYTE_W(BYTE_W), .OPEN_CODE(OPEN_CODE),
    .LOCK_CODE(LOCK_CODE), .BLANK_CODE(BLANK_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pendByte(pendByte),
    .accReq(accReq), .accWrite(accWrite), .wrLock(wrLock),
    .bootSel(bootSel), .dbgConnected(dbgConnected),
    .level(level), .accGrant(accGrant), .accBusErr(accBusErr)
  );

  assign protLevel         = level;
  assign optWrErr          = stb.wrReject;
  assign eraseReq          = stb.eraseHold;
  assign dbgPortEn         = (level != LVL_LOCK);
  assign bootRamAllowed    = (level != LVL_LOCK);
  assign bootLoaderAllowed = (level != LVL_LOCK);
endmodule

// File: rtl/rdp_checker.sv
`timescale 1ns/1ps
module rdp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       accReq,
  input logic       accWrite,
  input logic       accGrant,
  input logic       accBusErr,
  input logic       optWrReq,
  input logic       optWrErr,
  input logic       eraseReq,
  input logic [1:0] protLevel
);
  p_level_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    protLevel == 2'd2 |=> protLevel == 2'd2);

  p_erase_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> !accGrant);

  p_erase_from_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseReq) |-> protLevel == 2'd1);

  p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> $past(accReq));

  p_err_only_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    accBusErr |-> ($past(accReq) && !$past(accWrite)));

  p_resp_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(accGrant && accBusErr));

  p_wrerr_after_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    optWrErr |-> $past(optWrReq));
endmodule

bind rdprot_ctrl rdp_checker u_chk (
  .clk(clk), .rstN(rstN), .accReq(accReq), .accWrite(accWrite),
  .accGrant(accGrant), .accBusErr(accBusErr), .optWrReq(optWrReq),
  .optWrErr(optWrErr), .eraseReq(eraseReq), .protLevel(protLevel)
);

// File: tb/sim_rdprot_ctrl.sv
`timescale 1ns/1ps
module sim_rdprot_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] bootSel = 2'd0;
  logic       dbgConnected = 1'b0, accReq = 1'b0, accWrite = 1'b0, wrLock = 1'b0;
  logic       optWrReq = 1'b0, eraseDone = 1'b0;
  logic [7:0] optWrByte = 8'h00;
  logic       accGrant, accBusErr, optWrErr, eraseReq;
  logic [1:0] protLevel;
  logic       dbgPortEn, bootRamAllowed, bootLoaderAllowed;

  always #4 clk = ~clk;

  rdprot_ctrl u0 (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .dbgConnected(dbgConnected),
    .accReq(accReq), .accWrite(accWrite), .wrLock(wrLock),
    .optWrReq(optWrReq), .optWrByte(optWrByte), .eraseDone(eraseDone),
    .accGrant(accGrant), .accBusErr(accBusErr), .optWrErr(optWrErr),
    .eraseReq(eraseReq), .protLevel(protLevel), .dbgPortEn(dbgPortEn),
    .bootRamAllowed(bootRamAllowed), .bootLoaderAllowed(bootLoaderAllowed)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1", tagQ = "R1";

  // behavioural reference: 0 idle, 1 erasing, 2 committing, 3 waiting for level
  int   mLevel = 1, mState = 0;
  logic [7:0] mByte = 8'hFF, mPend = 8'h00;
  bit   mGrant = 0, mBusErr = 0, mWrErr = 0;

  function automatic int levelOf(input logic [7:0] b);
    if (b == 8'hAA) return 0;
    if (b == 8'hCC) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    tagQ <= tag;
    if (!rstN) begin
      mLevel = 1; mState = 0; mByte = 8'hFF;
      mGrant = 0; mBusErr = 0; mWrErr = 0;
    end else begin
      bit   stop, nWrErr;
      int   nState, nLevel;
      logic [7:0] nByte;
      stop = (mState == 1) || (mLevel != 0 && (dbgConnected || bootSel != 2'd0))
             || (accWrite && wrLock);
      mGrant  = accReq && !stop;
      mBusErr = accReq && !accWrite && stop;
      nLevel = levelOf(mByte);
      nByte  = mByte;
      nState = mState;
      nWrErr = 0;
      if (mState == 0) begin
        if (optWrReq) begin
          if (mLevel == 2) nWrErr = 1;
          else begin
            mPend  = optWrByte;
            nState = (mLevel == 1 && optWrByte == 8'hAA) ? 1 : 2;
          end
        end
      end else begin
        nWrErr = optWrReq;
        if (mState == 1) begin
          if (eraseDone) nState = 2;
        end else if (mState == 2) begin
          nByte = mPend; nState = 3;
        end else nState = 0;
      end
      mLevel = nLevel; mByte = nByte; mState = nState; mWrErr = nWrErr;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tagQ, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("accGrant", accGrant, mGrant);
      check("accBusErr", accBusErr, mBusErr);
      check("optWrErr", optWrErr, mWrErr);
      check("eraseReq", eraseReq, mState == 1);
      check("protLevel", protLevel, mLevel);
      check("dbgPortEn", dbgPortEn, mLevel != 2);
      check("bootRamAllowed", bootRamAllowed, mLevel != 2);
      check("bootLoaderAllowed", bootLoaderAllowed, mLevel != 2);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    accReq = 0; optWrReq = 0; eraseDone = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input bit wr, input bit lock, input logic [1:0] boot, input bit dbg);
    accReq = 1; accWrite = wr; wrLock = lock; bootSel = boot; dbgConnected = dbg;
    @(negedge clk);
    accReq = 0; wrLock = 0; bootSel = 0; dbgConnected = 0;
  endtask

  task automatic optWrite(input logic [7:0] b);
    optWrReq = 1; optWrByte = b;
    @(negedge clk);
    optWrReq = 0;
  endtask

  task automatic doReset();
    rstN = 0; idle(3); rstN = 1;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    tag = "R1"; idle(3);
    tag = "R4"; access(0, 0, 2'd0, 0); access(1, 0, 2'd0, 0); idle(1);
    tag = "R3"; access(0, 0, 2'd0, 1); access(1, 0, 2'd0, 1); access(0, 0, 2'd2, 0);
    access(0, 0, 2'd1, 0); access(1, 0, 2'd3, 0); idle(1);
    tag = "R10"; access(1, 1, 2'd0, 0); access(0, 1, 2'd0, 0); idle(1);
    tag = "R7"; optWrite(8'h55); idle(4);
    tag = "R9"; optWrite(8'h12); optWrite(8'h34); optWrite(8'h56); idle(4);
    tag = "R5"; optWrite(8'hAA); idle(2);
    tag = "R6"; access(0, 0, 2'd0, 0); access(1, 0, 2'd0, 0);
    tag = "R9"; optWrite(8'hCC);
    tag = "R5"; accReq = 1; accWrite = 0; optWrReq = 1; optWrByte = 8'h77; eraseDone = 1;
    @(negedge clk);
    idle(2); access(0, 0, 2'd0, 0); idle(3);
    tag = "R2"; access(0, 0, 2'd2, 1); access(1, 0, 2'd1, 1); access(0, 0, 2'd3, 0); idle(1);
    tag = "R10"; access(1, 1, 2'd2, 1); idle(1);
    tag = "R7"; optWrite(8'hAA); idle(4); optWrite(8'h3C); idle(4);
    optWrite(8'hCC); idle(4);
    tag = "R8"; optWrite(8'hAA); optWrite(8'h00); idle(4); access(0, 0, 2'd0, 1);
    access(1, 0, 2'd0, 0); idle(2);
    tag = "R3";
    for (int r = 0; r < 6; r++) begin
      doReset();
      for (int c = 0; c < 600; c++) begin
        int pick;
        accReq = $urandom_range(0, 1); accWrite = $urandom_range(0, 1);
        wrLock = ($urandom_range(0, 3) == 0); bootSel = 2'($urandom_range(0, 3));
        dbgConnected = ($urandom_range(0, 2) == 0);
        optWrReq = ($urandom_range(0, 5) == 0);
        pick = $urandom_range(0, 15);
        optWrByte = (pick < 6) ? 8'hAA : (pick == 6) ? 8'hCC : 8'($urandom_range(0, 255));
        eraseDone = ($urandom_range(0, 3) == 0);
        @(negedge clk);
      end
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule